// File: doc/BRIEF.md
# Cascadable parallel-to-serial shift register

The block holds a chain of register stages that either takes a whole parallel word in one step or moves serial data through the chain one stage at a time. The last stage drives a serial output and its complement. Tying the serial output of one instance to the serial input of the next makes a longer converter.

Everything runs on one fast system clock. The external shift clock, its active-low enable and the active-low load strobe are slow, clock-like signals. Each passes through a two-flop synchronizer. The shift clock and the enable are combined with a logical OR, so a rising edge on either one can move the data. A shift is issued when the synchronized OR goes from 0 to 1 on consecutive samples. Load is level-sensitive and overrides shifting. The serial and parallel data inputs are sampled directly, so they must be stable around a shift or a load.

The data path has a fixed latency. A stage update becomes visible on the outputs at the third system clock edge after the raw input change: two synchronizer flops, then the stage register.

Top module: `psr_shift_top`

## Requirements
- R1: While `load_n` is low, every stage i takes `par_in[i]` after the synchronizer latency, so `ser_out` equals `par_in[STAGES-1]`. Clock and enable activity during the load changes nothing.
- R2: With `load_n` high, each rising edge of (`sclk` OR `sclk_en_n`) moves the data one stage. `ser_in` enters stage 0, stage i goes to stage i+1, and `ser_out` is the last stage. After a load, the parallel bits come out highest index first.
- R3: A low-to-high change on `sclk_en_n` while `sclk` is low forms a rising edge of the OR and shifts once. The falling change that follows does not shift.
- R4: With `load_n` high and `sclk_en_n` high, toggling `sclk` leaves the stages unchanged.
- R5: `ser_out_n` is always the inverse of `ser_out`.
- R6: Releasing `load_n` while both `sclk` and `sclk_en_n` are low causes no shift. Releasing it while the OR is already high causes no shift either. Only a later rising edge of the OR shifts.
- R7: While `rst_n` is low at a clock edge, all stages and the edge history clear to 0, so `ser_out` is 0 and `ser_out_n` is 1.
- R8: Two instances sharing the clock, enable and load inputs, with the first one's `ser_out` feeding the second one's `ser_in`, produce 16 bits from the second instance. Its own word comes first, highest index first, then the first instance's word.
- R9: A rising edge of the OR that stays high for many system cycles causes exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_n | input | 1 | Parallel load strobe, active low, level-sensitive |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | STAGES | Parallel word, bit i goes to stage i |
| sclk | input | 1 | Shift clock, ORed with `sclk_en_n` |
| sclk_en_n | input | 1 | Active-low shift enable, ORed with `sclk` |
| ser_out | output | 1 | Last stage |
| ser_out_n | output | 1 | Inverse of the last stage |

## Verification
The assertions check on every cycle that:
- a synchronized load copies the parallel word and never coincides with a shift;
- a shift moves the chain by exactly one place;
- idle cycles keep the stages unchanged;
- two shifts never come back to back;
- a shift only follows a 0-to-1 change of the synchronized OR;
- the two outputs stay complementary.

Only the bench scenarios show the behaviour at the raw pins. These cover shifting by the enable alone, clock toggles being ignored while the enable is high, load release with the OR low or high, a long clock-high period, and the 16-bit order of a cascaded pair.

// File: rtl/psr_pkg.sv
// Package: shared types for the parallel-to-serial shift register.
// Assumes: nothing beyond IEEE 1800-2017.
package psr_pkg;

    // Next action of the stage chain on a system clock edge.
    typedef enum logic [1:0] {
        PSR_HOLD  = 2'd0,
        PSR_LOAD  = 2'd1,
        PSR_SHIFT = 2'd2
    } psr_mode_e;

endpackage

// File: rtl/psr_sync.sv
// Module: multi-flop synchronizer for a small vector of slow inputs.
// Assumes: each bit is an independent level; DEPTH >= 1; the reset value is
// chosen so that reset leaves the bit in its inactive state.
module psr_sync #(
    parameter int          W       = 1,
    parameter int          DEPTH   = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [DEPTH];

    // Shift the sampled inputs through DEPTH flops, clearing to RST_VAL.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[DEPTH-1];

endmodule

// File: rtl/psr_edge.sv
// Module: combines the synchronized clock and enable with an OR and issues
// a one-cycle shift pulse on a 0-to-1 change of that OR.
// Assumes: inputs are already synchronized. While load is active, the
// history still follows the OR but no pulse is issued.
module psr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic en_n_s,
    input  logic load_n_s,
    output logic or_s,
    output logic shift_go
);

    logic hist_q;

    assign or_s = sclk_s | en_n_s;

    // Remember the previous OR sample; clear to 0 in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= or_s;
    end

    // Pulse on a rising OR, suppressed while load holds the stages.
    assign shift_go = or_s & ~hist_q & load_n_s;

endmodule

// File: rtl/psr_stages.sv
// Module: the stage chain itself; load, shift or hold per system cycle.
// Assumes: shift_go is never high while load_n_s is low (load wins anyway).
module psr_stages
    import psr_pkg::*;
#(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n_s,
    input  logic              shift_go,
    input  logic              ser_in,
    input  logic [STAGES-1:0] par_in,
    output logic [STAGES-1:0] stages_q
);

    psr_mode_e mode;

    // Choose the action: load has priority over shift, otherwise hold.
    always_comb begin
        if (!load_n_s)     mode = PSR_LOAD;
        else if (shift_go) mode = PSR_SHIFT;
        else               mode = PSR_HOLD;
    end

    // Update the chain according to the chosen action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stages_q <= '0;
        end else begin
            case (mode)
                PSR_LOAD:  stages_q <= par_in;
                PSR_SHIFT: stages_q <= {stages_q[STAGES-2:0], ser_in};
                default:   stages_q <= stages_q;
            endcase
        end
    end

endmodule

// File: rtl/psr_shift_top.sv
// Module: cascadable parallel-to-serial shift register, top level.
// Assumes: sclk, sclk_en_n and load_n are slow relative to clk (each level
// held for at least three clk cycles); ser_in and par_in are stable while a
// shift or load is being taken.
module psr_shift_top #(
    parameter int STAGES     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              ser_in,
    input  logic [STAGES-1:0] par_in,
    input  logic              sclk,
    input  logic              sclk_en_n,
    output logic              ser_out,
    output logic              ser_out_n
);

    logic [1:0]        clk_pair_s;
    logic              load_n_s;
    logic              or_s;
    logic              shift_go;
    logic [STAGES-1:0] stages_q;

    // Clock and enable synchronizer; resets to 0.
    psr_sync #(.W(2), .DEPTH(SYNC_DEPTH), .RST_VAL(2'b00)) clk_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, sclk_en_n}),
        .q     (clk_pair_s)
    );

    // Load synchronizer; resets to the inactive level.
    psr_sync #(.W(1), .DEPTH(SYNC_DEPTH), .RST_VAL(1'b1)) load_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (load_n),
        .q     (load_n_s)
    );

    psr_edge edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (clk_pair_s[1]),
        .en_n_s   (clk_pair_s[0]),
        .load_n_s (load_n_s),
        .or_s     (or_s),
        .shift_go (shift_go)
    );

    psr_stages #(.STAGES(STAGES)) stages_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n_s (load_n_s),
        .shift_go (shift_go),
        .ser_in   (ser_in),
        .par_in   (par_in),
        .stages_q (stages_q)
    );

    assign ser_out   = stages_q[STAGES-1];
    assign ser_out_n = ~stages_q[STAGES-1];

endmodule

// File: rtl/psr_shift_chk.sv
// Module: assertion checker bound to psr_shift_top.
// Assumes: observes internal synchronized signals through the bind only.
module psr_shift_chk #(
    parameter int STAGES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_n_s,
    input logic              or_s,
    input logic              shift_go,
    input logic              ser_in,
    input logic [STAGES-1:0] par_in,
    input logic [STAGES-1:0] stages_q,
    input logic              ser_out,
    input logic              ser_out_n
);

    // R1
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n_s |=> stages_q == $past(par_in));

    // R6
    load_blocks_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n_s |-> !shift_go);

    // R2
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_go |=> stages_q == {$past(stages_q[STAGES-2:0]), $past(ser_in)});

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_s && !shift_go) |=> $stable(stages_q));

    // R9
    single_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_go |=> !shift_go);

    // R3
    rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_go |-> (or_s && !$past(or_s)));

    // R5
    inverse_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out_n == !ser_out);

endmodule

bind psr_shift_top psr_shift_chk #(.STAGES(STAGES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n_s  (load_n_s),
    .or_s      (or_s),
    .shift_go  (shift_go),
    .ser_in    (ser_in),
    .par_in    (par_in),
    .stages_q  (stages_q),
    .ser_out   (ser_out),
    .ser_out_n (ser_out_n)
);

// File: tb/psr_shift_top_tb_top.sv
// Bench: directed scenarios for psr_shift_top, including a cascaded pair.
module psr_shift_top_tb_top;

    localparam int N = 8;
    localparam int SETTLE = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_n = 1'b1;
    logic         sin = 1'b0;
    logic [N-1:0] par_a = '0;
    logic [N-1:0] par_b = '0;
    logic         sclk = 1'b0;
    logic         en_n = 1'b0;
    logic         out_a, out_a_n, out_b, out_b_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    psr_shift_top #(.STAGES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .ser_in(sin),
        .par_in(par_a), .sclk(sclk), .sclk_en_n(en_n),
        .ser_out(out_a), .ser_out_n(out_a_n)
    );

    psr_shift_top #(.STAGES(N)) casc_i (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .ser_in(out_a),
        .par_in(par_b), .sclk(sclk), .sclk_en_n(en_n),
        .ser_out(out_b), .ser_out_n(out_b_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic do_load(input logic [N-1:0] a, input logic [N-1:0] b);
        par_a = a; par_b = b; load_n = 1'b0; settle();
        load_n = 1'b1; settle();
    endtask

    task automatic pulse_sclk();
        sclk = 1'b1; settle(); sclk = 1'b0; settle();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // R7: reset clears the stages.
    task automatic t_reset();
        rst_n = 1'b0; repeat (4) @(negedge clk);
        chk("R7 reset out", out_a, 1'b0);
        chk("R7 reset out_n", out_a_n, 1'b1);
        rst_n = 1'b1; settle();
        chk("R7 after release", out_a, 1'b0);
    endtask

    // R1 R2 R5: load, then shift the word and a serial pattern through.
    task automatic t_load_shift(input logic [N-1:0] a, input logic [N-1:0] s);
        sclk = 1'b0; en_n = 1'b0;
        do_load(a, '0);
        chk("R1 load msb", out_a, a[N-1]);
        chk("R5 inverse", out_a_n, ~a[N-1]);
        for (int i = 0; i < N; i++) begin
            sin = s[i]; pulse_sclk();
            chk("R2 shift", out_a, (i + 1 < N) ? a[N-2-i] : s[0]);
            chk("R5 inverse", out_a_n, ~out_a);
        end
        sin = 1'b0;
        for (int j = 1; j < N; j++) begin
            pulse_sclk();
            chk("R2 serial through", out_a, s[j]);
        end
    endtask

    // R3: enable alone forms the shift edge.
    task automatic t_enable_shift(input logic [N-1:0] a);
        sclk = 1'b0; en_n = 1'b0;
        do_load(a, '0);
        en_n = 1'b1; settle();
        chk("R3 enable rise shifts", out_a, a[N-2]);
        en_n = 1'b0; settle();
        chk("R3 enable fall no shift", out_a, a[N-2]);
        en_n = 1'b1; settle();
        chk("R3 second enable rise", out_a, a[N-3]);
        en_n = 1'b0; settle();
    endtask

    // R4 R6: enable high holds; release with OR high does not shift.
    task automatic t_hold(input logic [N-1:0] a);
        sclk = 1'b0; en_n = 1'b1; settle();
        do_load(a, '0);
        chk("R6 release with OR high", out_a, a[N-1]);
        for (int k = 0; k < 3; k++) begin
            pulse_sclk();
            chk("R4 hold while disabled", out_a, a[N-1]);
        end
        sclk = 1'b1; settle(); en_n = 1'b0; settle(); sclk = 1'b0; settle();
    endtask

    // R1 R6: clocks during load ignored; release with OR low does not shift.
    task automatic t_load_release(input logic [N-1:0] a);
        sclk = 1'b0; en_n = 1'b0; par_a = a;
        load_n = 1'b0; settle();
        pulse_sclk(); pulse_sclk();
        chk("R1 clocks ignored in load", out_a, a[N-1]);
        load_n = 1'b1; settle();
        chk("R6 release with OR low", out_a, a[N-1]);
        pulse_sclk();
        chk("R6 later edge shifts", out_a, a[N-2]);
    endtask

    // R9: long clock high gives one shift.
    task automatic t_single(input logic [N-1:0] a);
        sclk = 1'b0; en_n = 1'b0;
        do_load(a, '0);
        sclk = 1'b1; repeat (40) @(negedge clk);
        chk("R9 single shift", out_a, a[N-2]);
        sclk = 1'b0; settle();
        chk("R9 fall no shift", out_a, a[N-2]);
    endtask

    // R8: cascade gives 16 bits, second word first.
    task automatic t_cascade(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [2*N-1:0] word;
        sclk = 1'b0; en_n = 1'b0; sin = 1'b0;
        word = {b, a};
        do_load(a, b);
        chk("R8 cascade bit 15", out_b, word[2*N-1]);
        for (int i = 1; i < 2*N; i++) begin
            pulse_sclk();
            chk("R8 cascade", out_b, word[2*N-1-i]);
        end
        chk("R5 cascade inverse", out_b_n, ~out_b);
    endtask

    initial begin
        t_reset();
        t_load_shift(8'hA5, 8'h3C);
        t_load_shift(8'h81, 8'hF0);
        t_enable_shift(8'h6D);
        t_hold(8'hC3);
        t_load_release(8'h5A);
        t_single(8'hB4);
        t_cascade(8'h96, 8'h1E);
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

endmodule